// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command decoder of a single-bit SPI serial NOR flash. It oversamples chip select, serial clock and serial data in the system clock domain. It assembles the opcode, address and data bytes of each transaction and turns them into single-cycle strobes toward a memory back-end. The back-end owns the array, the status bits other than the write-enable latch, and all program and erase timing.

The block holds the write-enable latch and the reset-enable arming state. A write-type command is qualified when chip select rises. It runs only if the number of serial clocks in the transaction was a whole number of bytes and the latch was set. Read-type commands stream bytes on the serial output for as long as the master keeps clocking. The master may stop them at any bit. Page-program data bytes are handed to the back-end as they arrive. A final commit or cancel strobe then tells the back-end whether to use them.

Serial timing assumed: SPI mode 0, with each serial clock phase lasting at least six system clocks. Read data from the back-end must be valid from the cycle after `rd_req` until the next `rd_req`.

Top module: `sfc_frontend`

## Requirements
- R1: Each bit is sampled on a rising serial clock edge while chip select is low, most significant bit first. The first byte is the opcode. Multi-byte addresses arrive high byte first.
- R2: A byte-aligned transaction with opcode 0x06 sets the write-enable latch, and one with opcode 0x04 clears it. The latch is visible on `wel` and as bit 1 of status byte 0.
- R3: A write-type transaction (0x06, 0x04, 0x01/0x31/0x11, 0x02, 0x20/0x52/0xD8, 0xC7/0x60, 0x99) whose clock count at chip select rise is not a multiple of eight is discarded. No execute strobe is raised and the latch keeps its value.
- R4: With the latch set, opcodes 0x20, 0x52 and 0xD8 followed by three address bytes execute as kind 1, 2 and 3, with that address. Opcodes 0xC7 and 0x60 execute as kind 4. A successful execute clears the latch.
- R5: With the latch set, opcode 0x02 plus an address produces one `pg_vld` strobe per data byte. The strobe's address increments in its low 8 bits only, wrapping within the page. An aligned end with at least one data byte executes kind 0 with the start address and clears the latch.
- R6: A page program that ends on a partial byte, or with no data byte, raises `pg_cancel` instead of an execute and leaves the latch set.
- R7: With the latch set, opcodes 0x01, 0x31 and 0x11 followed by one data byte execute kind 5, with `exec_sr_sel` 0, 1 and 2 and that data byte. With no data byte the command is discarded.
- R8: Program, erase and status-write commands issued while the latch is clear produce no execute and no `pg_vld` strobe.
- R9: Opcodes 0x05, 0x35 and 0x15 return status byte 0, 1 and 2 (`sr_in[7:0]`, `[15:8]`, `[23:16]`, with bit 1 of byte 0 replaced by the latch). The byte repeats for as long as clocks continue.
- R10: Opcode 0x03 plus an address raises `rd_req` at each byte boundary of the data phase, with an incrementing address. The returned bytes are shifted out MSB first, and the output changes only after a falling serial clock edge.
- R11: Opcode 0x0B inserts one dummy byte after the address before data output begins.
- R12: Raising chip select during any bit of a read ends it. The output enable drops and nothing executes.
- R13: Opcode 0x99 executes kind 6 and clears the latch only if the immediately preceding transaction was an aligned 0x66. Any other transaction in between disarms it.
- R14: Unknown opcodes change nothing, and the output enable stays low until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| sr_in | input | 24 | Status bytes 2..0 from the back-end |
| rd_req | output | 1 | Read fetch strobe |
| rd_addr | output | 24 | Read fetch address |
| rd_data | input | 8 | Read byte, valid from the cycle after rd_req |
| pg_vld | output | 1 | Page-program data byte strobe |
| pg_addr | output | 24 | Address of the page-program byte |
| pg_data | output | 8 | Page-program data byte |
| pg_cancel | output | 1 | Discard the buffered page-program bytes |
| exec_vld | output | 1 | Execute strobe |
| exec_kind | output | 3 | 0 program, 1 sector, 2 32K, 3 64K, 4 chip erase, 5 status write, 6 reset |
| exec_addr | output | 24 | Start address of program or erase |
| exec_sr_sel | output | 2 | Status byte index for a status write |
| exec_sr_data | output | 8 | Status write data |
| wel | output | 1 | Write-enable latch |

## Verification
The bench builds the block with its defaults: a 24-bit address, an 8-bit page offset and two synchronizer stages. A single-bit serial link makes each one-byte transaction short, so the bench can sweep all 256 opcodes after setting the latch and predict the latch and any execute for each one. The default page size puts the wrap from offset 0xFF to 0x00 within reach of a three-byte program. Partial final bytes, aborted reads and every ordering of reset enable and reset are driven explicitly.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR0 = 8'h05;
  localparam logic [7:0] OP_RDSR1 = 8'h35;
  localparam logic [7:0] OP_RDSR2 = 8'h15;
  localparam logic [7:0] OP_WRSR0 = 8'h01;
  localparam logic [7:0] OP_WRSR1 = 8'h31;
  localparam logic [7:0] OP_WRSR2 = 8'h11;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_BE32  = 8'h52;
  localparam logic [7:0] OP_BE64  = 8'hD8;
  localparam logic [7:0] OP_CEA   = 8'hC7;
  localparam logic [7:0] OP_CEB   = 8'h60;
  localparam logic [7:0] OP_RSTEN = 8'h66;
  localparam logic [7:0] OP_RST   = 8'h99;

  typedef enum logic [2:0] {
    EX_PROG = 3'd0,
    EX_SE   = 3'd1,
    EX_BE32 = 3'd2,
    EX_BE64 = 3'd3,
    EX_CE   = 3'd4,
    EX_WRSR = 3'd5,
    EX_RST  = 3'd6
  } exec_kind_e;
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= st[s-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sfc_deser.sv
module sfc_deser #(
  parameter int BN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_s,
  input  logic            sclk_s,
  input  logic            si_s,
  output logic            cs_fall,
  output logic            cs_rise,
  output logic            sclk_fall,
  output logic            byte_vld,
  output logic [7:0]      byte_data,
  output logic [BN_W-1:0] byte_num,
  output logic            aligned,
  output logic            any_clk
);
  logic            cs_prev_q, sclk_prev_q;
  logic [2:0]      bit_q, bit_d;
  logic [BN_W-1:0] bn_q, bn_d, bn_inc;
  logic [6:0]      sh_q, sh_d;
  logic            sclk_rise;

  assign cs_fall   = cs_prev_q & ~cs_s;
  assign cs_rise   = ~cs_prev_q & cs_s;
  assign sclk_rise = ~cs_s & sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~cs_s & ~sclk_s & sclk_prev_q;
  assign bn_inc    = (bn_q == '1) ? bn_q : bn_q + 1'b1;
  assign byte_vld  = sclk_rise && (bit_q == 3'd7);
  assign byte_data = {sh_q, si_s};
  assign byte_num  = byte_vld ? bn_inc : bn_q;
  assign aligned   = (bit_q == 3'd0);
  assign any_clk   = (bit_q != 3'd0) || (bn_q != '0);

  always_comb begin
    bit_d = bit_q;
    bn_d  = bn_q;
    sh_d  = sh_q;
    if (cs_fall) begin
      bit_d = '0;
      bn_d  = '0;
    end else if (sclk_rise) begin
      sh_d  = {sh_q[5:0], si_s};
      bit_d = bit_q + 1'b1;
      if (bit_q == 3'd7) bn_d = bn_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      bit_q       <= '0;
      bn_q        <= '0;
      sh_q        <= '0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
      bit_q       <= bit_d;
      bn_q        <= bn_d;
      sh_q        <= sh_d;
    end
  end
endmodule

// File: rtl/sfc_serializer.sv
module sfc_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       sclk_fall,
  input  logic       load,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       miso_oe
);
  logic       pend_q, pend_d;
  logic       oe_q, oe_d;
  logic [7:0] sh_q, sh_d;

  always_comb begin
    pend_d = pend_q;
    oe_d   = oe_q;
    sh_d   = sh_q;
    if (cs_fall || cs_rise) begin
      pend_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      if (load) pend_d = 1'b1;
      if (sclk_fall) begin
        if (pend_q) begin
          sh_d   = tx_byte;
          oe_d   = 1'b1;
          pend_d = load;
        end else if (oe_q) begin
          sh_d = {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      oe_q   <= 1'b0;
      sh_q   <= '0;
    end else begin
      pend_q <= pend_d;
      oe_q   <= oe_d;
      sh_q   <= sh_d;
    end
  end

  assign miso    = oe_q & sh_q[7];
  assign miso_oe = oe_q;

  // R12
  miso_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !oe_q);

  // R10
  shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(sh_q));

  // R14
  oe_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(pend_q));
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int PAGE_AW = 8,
  parameter int BN_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic              aligned,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [BN_W-1:0]   byte_num,
  input  logic [23:0]       sr_in,
  input  logic [7:0]        rd_data,
  output logic              tx_load,
  output logic [7:0]        tx_byte,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pg_vld,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              pg_cancel,
  output logic              exec_vld,
  output logic [2:0]        exec_kind,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [1:0]        exec_sr_sel,
  output logic [7:0]        exec_sr_data,
  output logic              wel
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [BN_W-1:0] BN_OP   = BN_W'(1);
  localparam logic [BN_W-1:0] BN_SR   = BN_W'(2);
  localparam logic [BN_W-1:0] BN_ADDR = BN_W'(ADDR_BYTES + 1);
  localparam logic [BN_W-1:0] BN_DMY  = BN_W'(ADDR_BYTES + 2);

  logic [7:0]        op_q, op_d, op_now;
  logic [ADDR_W-1:0] addr_q, addr_d, base_q, base_d, addr_sh;
  logic [7:0]        srd_q, srd_d;
  logic              wel_q, wel_d, armed_q, armed_d, fetch_q, fetch_d;
  logic              pgv_q, pgv_d, pgc_q, pgc_d, exv_q, exv_d;
  logic [ADDR_W-1:0] pga_q, pga_d;
  logic [7:0]        pgd_q, pgd_d;
  exec_kind_e        exk_q, exk_d;
  logic [1:0]        exs_q, exs_d;
  logic              op_is_sr, ok_end, now_rd, now_fr, now_sr;

  assign op_now   = (byte_num == BN_OP) ? byte_data : op_q;
  assign op_is_sr = (op_q == OP_RDSR0) || (op_q == OP_RDSR1) || (op_q == OP_RDSR2);
  assign now_rd   = (op_now == OP_READ)  && (byte_num >= BN_ADDR);
  assign now_fr   = (op_now == OP_FREAD) && (byte_num >= BN_DMY);
  assign now_sr   = ((op_now == OP_RDSR0) || (op_now == OP_RDSR1) ||
                     (op_now == OP_RDSR2)) && (byte_num >= BN_OP);
  assign ok_end   = aligned && (byte_num >= BN_OP);
  assign addr_sh  = {addr_q[ADDR_W-9:0], byte_data};

  always_comb begin
    op_d    = op_q;
    addr_d  = addr_q;
    base_d  = base_q;
    srd_d   = srd_q;
    wel_d   = wel_q;
    armed_d = armed_q;
    fetch_d = byte_vld && (now_rd || now_fr || now_sr);
    pgv_d   = 1'b0;
    pga_d   = pga_q;
    pgd_d   = pgd_q;
    pgc_d   = 1'b0;
    exv_d   = 1'b0;
    exk_d   = exk_q;
    exs_d   = exs_q;

    if (fetch_q && !op_is_sr) addr_d = addr_q + 1'b1;

    if (byte_vld) begin
      if (byte_num == BN_OP) op_d = byte_data;
      if (byte_num == BN_SR) srd_d = byte_data;
      if ((byte_num > BN_OP) && (byte_num <= BN_ADDR)) begin
        addr_d = addr_sh;
        if (byte_num == BN_ADDR) base_d = addr_sh;
      end
      if ((op_q == OP_PROG) && (byte_num > BN_ADDR) && wel_q) begin
        pgv_d  = 1'b1;
        pga_d  = addr_q;
        pgd_d  = byte_data;
        addr_d = {addr_q[ADDR_W-1:PAGE_AW], addr_q[PAGE_AW-1:0] + 1'b1};
      end
    end

    if (cs_rise && (byte_num >= BN_OP || !aligned)) begin
      armed_d = ok_end && (op_q == OP_RSTEN);
      case (op_q)
        OP_WREN: if (ok_end) wel_d = 1'b1;
        OP_WRDI: if (ok_end) wel_d = 1'b0;
        OP_WRSR0, OP_WRSR1, OP_WRSR2:
          if (ok_end && (byte_num >= BN_SR) && wel_q) begin
            exv_d = 1'b1;
            exk_d = EX_WRSR;
            exs_d = (op_q == OP_WRSR0) ? 2'd0 : (op_q == OP_WRSR1) ? 2'd1 : 2'd2;
          end
        OP_SE, OP_BE32, OP_BE64:
          if (ok_end && (byte_num >= BN_ADDR) && wel_q) begin
            exv_d = 1'b1;
            exk_d = (op_q == OP_SE) ? EX_SE : (op_q == OP_BE32) ? EX_BE32 : EX_BE64;
          end
        OP_CEA, OP_CEB:
          if (ok_end && wel_q) begin
            exv_d = 1'b1;
            exk_d = EX_CE;
          end
        OP_PROG:
          if (wel_q) begin
            if (ok_end && (byte_num > BN_ADDR)) begin
              exv_d = 1'b1;
              exk_d = EX_PROG;
            end else begin
              pgc_d = 1'b1;
            end
          end
        OP_RST:
          if (ok_end && armed_q) begin
            exv_d = 1'b1;
            exk_d = EX_RST;
          end
        default: ;
      endcase
      if (exv_d) wel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      srd_q   <= '0;
      wel_q   <= 1'b0;
      armed_q <= 1'b0;
      fetch_q <= 1'b0;
      pgv_q   <= 1'b0;
      pga_q   <= '0;
      pgd_q   <= '0;
      pgc_q   <= 1'b0;
      exv_q   <= 1'b0;
      exk_q   <= EX_PROG;
      exs_q   <= '0;
    end else begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      base_q  <= base_d;
      srd_q   <= srd_d;
      wel_q   <= wel_d;
      armed_q <= armed_d;
      fetch_q <= fetch_d;
      pgv_q   <= pgv_d;
      pga_q   <= pga_d;
      pgd_q   <= pgd_d;
      pgc_q   <= pgc_d;
      exv_q   <= exv_d;
      exk_q   <= exk_d;
      exs_q   <= exs_d;
    end
  end

  always_comb begin
    case (op_q)
      OP_RDSR0: tx_byte = {sr_in[7:2], wel_q, sr_in[0]};
      OP_RDSR1: tx_byte = sr_in[15:8];
      OP_RDSR2: tx_byte = sr_in[23:16];
      default:  tx_byte = rd_data;
    endcase
  end

  assign tx_load      = fetch_q;
  assign rd_req       = fetch_q && !op_is_sr;
  assign rd_addr      = addr_q;
  assign pg_vld       = pgv_q;
  assign pg_addr      = pga_q;
  assign pg_data      = pgd_q;
  assign pg_cancel    = pgc_q;
  assign exec_vld     = exv_q;
  assign exec_kind    = exk_q;
  assign exec_addr    = base_q;
  assign exec_sr_sel  = exs_q;
  assign exec_sr_data = srd_q;
  assign wel          = wel_q;

  // R8
  exec_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exv_q && exk_q != EX_RST) |-> $past(wel_q));

  // R4
  wel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exv_q |-> !wel_q);

  // R3
  exec_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exv_q |-> $past(cs_rise && aligned));

  // R6
  commit_or_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exv_q, pgc_q}));

  // R5
  pg_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgv_q |-> wel_q);
endmodule

// File: rtl/sfc_frontend.sv
module sfc_frontend #(
  parameter int ADDR_W      = 24,
  parameter int PAGE_AW     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [23:0]       sr_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              pg_vld,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              pg_cancel,
  output logic              exec_vld,
  output logic [2:0]        exec_kind,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [1:0]        exec_sr_sel,
  output logic [7:0]        exec_sr_data,
  output logic              wel
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int BN_W       = $clog2(ADDR_BYTES + 4);

  logic [1:0]      rst_pipe_q;
  logic            rst_core_n;
  logic [2:0]      pins_s;
  logic            cs_fall, cs_rise, sclk_fall, byte_vld, aligned, any_clk;
  logic [7:0]      byte_data, tx_byte;
  logic [BN_W-1:0] byte_num;
  logic            tx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  sfc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (pins_s)
  );

  sfc_deser #(.BN_W(BN_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cs_s      (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .si_s      (pins_s[0]),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .byte_num  (byte_num),
    .aligned   (aligned),
    .any_clk   (any_clk)
  );

  sfc_ctrl #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .BN_W(BN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cs_rise      (cs_rise & any_clk),
    .aligned      (aligned),
    .byte_vld     (byte_vld),
    .byte_data    (byte_data),
    .byte_num     (byte_num),
    .sr_in        (sr_in),
    .rd_data      (rd_data),
    .tx_load      (tx_load),
    .tx_byte      (tx_byte),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .pg_vld       (pg_vld),
    .pg_addr      (pg_addr),
    .pg_data      (pg_data),
    .pg_cancel    (pg_cancel),
    .exec_vld     (exec_vld),
    .exec_kind    (exec_kind),
    .exec_addr    (exec_addr),
    .exec_sr_sel  (exec_sr_sel),
    .exec_sr_data (exec_sr_data),
    .wel          (wel)
  );

  sfc_serializer u_ser (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .load      (tx_load),
    .tx_byte   (tx_byte),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );
endmodule

// File: tb/tb_sfc_frontend.sv
`timescale 1ns/1ps
module tb_sfc_frontend;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [23:0] sr_in = 24'h3C965D;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data = 8'h00;
  logic        pg_vld, pg_cancel, exec_vld, wel;
  logic [23:0] pg_addr, exec_addr;
  logic [7:0]  pg_data, exec_sr_data;
  logic [2:0]  exec_kind;
  logic [1:0]  exec_sr_sel;

  int n_run = 0, n_fail = 0;
  int ex_cnt = 0, pg_cnt = 0, cancel_cnt = 0, rd_cnt = 0;
  logic [2:0]  ex_kind;
  logic [23:0] ex_addr, first_rd;
  logic [1:0]  ex_sel;
  logic [7:0]  ex_data;
  logic [23:0] pga_log [8];
  logic [7:0]  pgd_log [8];
  logic        oe_seen = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sfc_frontend dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .sr_in(sr_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .pg_vld(pg_vld), .pg_addr(pg_addr), .pg_data(pg_data), .pg_cancel(pg_cancel),
    .exec_vld(exec_vld), .exec_kind(exec_kind), .exec_addr(exec_addr),
    .exec_sr_sel(exec_sr_sel), .exec_sr_data(exec_sr_data), .wel(wel)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (rd_req) begin
      rd_data <= mem_byte(rd_addr);
      if (rd_cnt == 0) first_rd = rd_addr;
      rd_cnt++;
    end
    if (exec_vld) begin
      ex_cnt++; ex_kind = exec_kind; ex_addr = exec_addr;
      ex_sel = exec_sr_sel; ex_data = exec_sr_data;
    end
    if (pg_vld) begin
      pga_log[pg_cnt % 8] = pg_addr; pgd_log[pg_cnt % 8] = pg_data; pg_cnt++;
    end
    if (pg_cancel) cancel_cnt++;
    if (spi_miso_oe) oe_seen = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic o);
    spi_mosi = b;
    repeat (H) @(negedge clk);
    o = spi_miso;
    spi_sclk = 1'b1;
    repeat (H) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], d);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    logic d;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], d);
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b0, d); v[i] = d; end
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  task automatic one(input logic [7:0] op);
    cs_lo(); put_byte(op); cs_hi();
  endtask

  task automatic with_addr(input logic [7:0] op, input logic [23:0] a);
    put_byte(op); put_byte(a[23:16]); put_byte(a[15:8]); put_byte(a[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int e0, p0, c0, r0;
    logic [7:0] v;
    logic [7:0] eops [3];
    logic [7:0] sops [3];
    eops[0] = 8'h20; eops[1] = 8'h52; eops[2] = 8'hD8;
    sops[0] = 8'h01; sops[1] = 8'h31; sops[2] = 8'h11;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("reset R2 wel", wel, 0);
    chk("reset R12 oe", spi_miso_oe, 0);
    chk("reset exec", ex_cnt, 0);

    one(8'h06); chk("R2 set latch", wel, 1);
    one(8'h04); chk("R2 clear latch", wel, 0);

    e0 = ex_cnt;
    cs_lo(); with_addr(8'h20, 24'h000100); cs_hi();
    chk("R8 erase without latch", ex_cnt - e0, 0);

    for (int i = 0; i < 3; i++) begin
      one(8'h06);
      e0 = ex_cnt;
      cs_lo(); with_addr(eops[i], 24'h123456 ^ 24'(i)); cs_hi();
      chk("R4 erase exec", ex_cnt - e0, 1);
      chk("R4 erase kind", ex_kind, i + 1);
      chk("R1 R4 erase address", ex_addr, 24'h123456 ^ 24'(i));
      chk("R4 latch cleared", wel, 0);
    end
    for (int i = 0; i < 2; i++) begin
      one(8'h06);
      e0 = ex_cnt;
      one(i == 0 ? 8'hC7 : 8'h60);
      chk("R4 chip erase", ex_cnt - e0, 1);
      chk("R4 chip kind", ex_kind, 4);
    end

    one(8'h06);
    e0 = ex_cnt;
    cs_lo(); put_byte(8'h20); put_byte(8'h00); put_byte(8'h10); put_bits(8'h00, 5); cs_hi();
    chk("R3 misaligned erase", ex_cnt - e0, 0);
    chk("R3 latch kept", wel, 1);
    one(8'h04);
    cs_lo(); put_byte(8'h06); put_bits(8'h00, 3); cs_hi();
    chk("R3 misaligned enable", wel, 0);

    one(8'h06);
    e0 = ex_cnt; p0 = pg_cnt;
    cs_lo(); with_addr(8'h02, 24'h0001FE); put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); cs_hi();
    chk("R5 data strobes", pg_cnt - p0, 3);
    chk("R5 addr 0", pga_log[p0 % 8], 24'h0001FE);
    chk("R5 addr wrap", pga_log[(p0 + 2) % 8], 24'h000100);
    chk("R5 data 1", pgd_log[(p0 + 1) % 8], 8'h22);
    chk("R5 exec", ex_cnt - e0, 1);
    chk("R5 kind", ex_kind, 0);
    chk("R5 start addr", ex_addr, 24'h0001FE);
    chk("R5 latch cleared", wel, 0);

    one(8'h06);
    e0 = ex_cnt; c0 = cancel_cnt;
    cs_lo(); with_addr(8'h02, 24'h000200); put_byte(8'h44); put_bits(8'hF0, 3); cs_hi();
    chk("R6 no exec", ex_cnt - e0, 0);
    chk("R6 cancel", cancel_cnt - c0, 1);
    chk("R6 latch kept", wel, 1);
    one(8'h04);

    e0 = ex_cnt; p0 = pg_cnt;
    cs_lo(); with_addr(8'h02, 24'h000300); put_byte(8'h55); cs_hi();
    chk("R8 program no strobe", pg_cnt - p0, 0);
    chk("R8 program no exec", ex_cnt - e0, 0);

    for (int i = 0; i < 3; i++) begin
      one(8'h06);
      e0 = ex_cnt;
      cs_lo(); put_byte(sops[i]); put_byte(8'hA0 + 8'(i)); cs_hi();
      chk("R7 status write exec", ex_cnt - e0, 1);
      chk("R7 kind", ex_kind, 5);
      chk("R7 select", ex_sel, i);
      chk("R7 data", ex_data, 8'hA0 + 8'(i));
    end
    one(8'h06);
    e0 = ex_cnt;
    one(8'h01);
    chk("R7 no data byte", ex_cnt - e0, 0);
    chk("R7 latch kept", wel, 1);

    cs_lo(); put_byte(8'h05); get_byte(v); chk("R9 sr0 with latch", v, 8'h5F);
    get_byte(v); chk("R9 sr0 repeat", v, 8'h5F); cs_hi();
    one(8'h04);
    cs_lo(); put_byte(8'h05); get_byte(v); chk("R9 sr0 no latch", v, 8'h5D); cs_hi();
    cs_lo(); put_byte(8'h35); get_byte(v); chk("R9 sr1", v, 8'h96); cs_hi();
    cs_lo(); put_byte(8'h15); get_byte(v); chk("R9 sr2", v, 8'h3C); cs_hi();

    r0 = rd_cnt; rd_cnt = 0;
    cs_lo(); with_addr(8'h03, 24'h00A0FF);
    for (int i = 0; i < 3; i++) begin
      get_byte(v); chk("R10 read byte", v, mem_byte(24'h00A0FF + 24'(i)));
    end
    cs_hi();
    chk("R10 first fetch addr", first_rd, 24'h00A0FF);
    chk("R10 fetch count", rd_cnt, 4);

    cs_lo(); with_addr(8'h0B, 24'h001234); put_byte(8'h00);
    get_byte(v); chk("R11 fast read 0", v, mem_byte(24'h001234));
    get_byte(v); chk("R11 fast read 1", v, mem_byte(24'h001235));
    cs_hi();

    one(8'h06);
    e0 = ex_cnt;
    cs_lo(); with_addr(8'h03, 24'h000010); put_bits(8'h00, 5);
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (14) @(negedge clk);
    chk("R12 oe released", spi_miso_oe, 0);
    chk("R12 nothing executed", ex_cnt - e0, 0);
    chk("R12 latch unchanged", wel, 1);

    e0 = ex_cnt;
    one(8'h66); one(8'h99);
    chk("R13 reset exec", ex_cnt - e0, 1);
    chk("R13 reset kind", ex_kind, 6);
    chk("R13 reset clears latch", wel, 0);
    e0 = ex_cnt;
    one(8'h99);
    chk("R13 reset without enable", ex_cnt - e0, 0);
    one(8'h66); one(8'h06); one(8'h99);
    chk("R13 enable disarmed", ex_cnt - e0, 0);
    cs_lo(); put_byte(8'h66); put_bits(8'h00, 3); cs_hi(); one(8'h99);
    chk("R13 misaligned enable", ex_cnt - e0, 0);

    e0 = ex_cnt; oe_seen = 1'b0;
    cs_lo(); put_byte(8'hAB); put_byte(8'h12); put_byte(8'h34); put_byte(8'h56); cs_hi();
    chk("R14 unknown oe low", oe_seen, 0);
    chk("R14 unknown no exec", ex_cnt - e0, 0);
    chk("R14 unknown latch", wel, 1);

    for (int op = 0; op < 256; op++) begin
      logic [7:0] o8;
      o8 = 8'(op);
      one(8'h06);
      e0 = ex_cnt;
      one(o8);
      chk($sformatf("R14 R2 sweep %02h latch", o8), wel,
          (o8 == 8'h04 || o8 == 8'hC7 || o8 == 8'h60) ? 0 : 1);
      chk($sformatf("R14 R4 sweep %02h exec", o8), ex_cnt - e0,
          (o8 == 8'hC7 || o8 == 8'h60) ? 1 : 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule